// File: doc/BRIEF.md
# Event-Prescaled Interrupt Pulse Generator

This block turns periodic timer strobes into a slower interrupt. A 3-bit source field picks one of six single-cycle PWM timer event inputs. Each selected event, or a software force strobe, advances a 2-bit event counter. When the count reaches a programmable period of 1, 2 or 3, the counter returns to zero and a match is declared. A period of 0 turns counting off.

A match raises a one-clock interrupt pulse and sets a latched status flag, but only while the interrupt enable is on and the flag is clear. Software acknowledges by strobing the flag clear input. Until it does, matches keep resetting the counter but produce no further pulses. The enable, source and period are loaded together by a configuration write strobe. Every such write empties the counter.

Top module: `evt_irq_gen`

## Requirements
- R1: After the active-low synchronous reset, `cnt_o` is 0, `flag_o` is 0, `irq_o` is 0. The enable, source field and period are all 0, so events and force strobes do nothing until a configuration write.
- R2: The source field maps `evt_i` bits as follows: code 001 uses bit 0 (timer at zero), 010 uses bit 1 (timer at period), 100 uses bit 2 (compare A rising), 101 uses bit 3 (compare A falling), 110 uses bit 4 (compare B rising) and 111 uses bit 5 (compare B falling). Codes 000 and 011 select nothing.
- R3: With a non-zero period, each cycle with a selected event raises `cnt_o` by one, and `cnt_o` always shows the current count.
- R4: When an increment would make the count equal to the period, the counter goes to 0 and a match occurs. Matches therefore fall on every 1st, 2nd or 3rd event.
- R5: With period 0, selected events and `force_i` leave the count at 0 and never produce a match.
- R6: `force_i` counts as one event. A force and a selected event in the same cycle add only one.
- R7: A cycle with `cfg_we` high loads the new configuration and sets the count to 0 at the next edge. That cycle produces no match, and any event or force in it is dropped.
- R8: A match with enable set and the flag clear drives `irq_o` high for one clock, in the same cycle that `flag_o` rises.
- R9: `flag_o` stays high until `flag_clr_i` is strobed. While it is high, matches still clear the counter but give no pulse.
- R10: If `flag_clr_i` and a match with enable set occur in the same cycle, the clear acts first. The flag then stays set and a new pulse is emitted.
- R11: A match with enable clear resets the counter, leaves the flag unchanged and emits no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe; loads enable, source and period, empties counter |
| cfg_en | input | 1 | Interrupt enable value to load |
| cfg_sel | input | 3 | Event source code to load |
| cfg_prd | input | 2 | Event period to load (0 = off) |
| force_i | input | 1 | Software force strobe, counts as one event |
| flag_clr_i | input | 1 | Status flag clear strobe |
| evt_i | input | 6 | Single-cycle timer event strobes |
| cnt_o | output | 2 | Current event count |
| flag_o | output | 1 | Latched interrupt status flag |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
Two pairs of functions can land in the same cycle. A flag clear can meet a fresh match, and a force strobe can meet a selected hardware event. The bench raises the clear strobe on the very cycle the count reaches the period. It also drives `force_i` together with the selected `evt_i` bit. The outcomes are judged against a bench model: the flag must stay high with a new pulse, and the count must rise by exactly one. A configuration write is also made on the same cycle as an event, and the event must be dropped.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int SEL_W = 3;
    localparam int N_EVT = 6;

    // source code assigned to evt_i bit index
    function automatic logic [SEL_W-1:0] src_code(input int idx);
        case (idx)
            0:       src_code = 3'b001;
            1:       src_code = 3'b010;
            2:       src_code = 3'b100;
            3:       src_code = 3'b101;
            4:       src_code = 3'b110;
            default: src_code = 3'b111;
        endcase
    endfunction
endpackage

// File: rtl/evt_irq_src_mux.sv
module evt_irq_src_mux
    import evt_irq_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_EVT-1:0] evt_i,
    output logic             hit_o
);
    logic [N_EVT-1:0] hit_vec;

    for (genvar g = 0; g < N_EVT; g++) begin : g_src
        assign hit_vec[g] = evt_i[g] && (sel_i == src_code(g));
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/evt_irq_prescaler.sv
module evt_irq_prescaler #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] prd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    localparam int NXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t             st_d, st_q;
    logic [NXT_W-1:0] nxt;
    logic             match_d;

    always_comb begin
        st_d    = st_q;
        match_d = 1'b0;
        nxt     = NXT_W'(st_q.cnt) + NXT_W'(1);
        if (wr_i) begin
            st_d.cnt = '0;
        end else if (inc_i && (prd_i != '0)) begin
            if (nxt == NXT_W'(prd_i)) begin
                st_d.cnt = '0;
                match_d  = 1'b1;
            end else begin
                st_d.cnt = nxt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign match_o = match_d;

    // R3
    cnt_below_prd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) || (st_q.cnt < prd_i));
    // R7
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.cnt == '0));
    // R5
    off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prd_i == '0) && !wr_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/evt_irq_latch.sv
module evt_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic en_i,
    input  logic clr_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
        logic irq;
    } lat_t;

    lat_t lat_d, lat_q;
    logic flag_eff;

    always_comb begin
        flag_eff  = lat_q.flag && !clr_i;
        lat_d.irq = match_i && en_i && !flag_eff;
        lat_d.flag = flag_eff || lat_d.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign flag_o = lat_q.flag;
    assign irq_o  = lat_q.irq;

    // R8
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q.irq |-> lat_q.flag);
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q.flag && !clr_i) |=> (lat_q.flag && !lat_q.irq));
    // R10
    clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && match_i && en_i) |=> (lat_q.flag && lat_q.irq));
    // R11
    no_irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !en_i) |=> !lat_q.irq);
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen
    import evt_irq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_en,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CNT_W-1:0] cfg_prd,
    input  logic             force_i,
    input  logic             flag_clr_i,
    input  logic [N_EVT-1:0] evt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             irq_o
);
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] prd;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic sel_hit;
    logic match;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.en  = cfg_en;
            cfg_d.sel = cfg_sel;
            cfg_d.prd = cfg_prd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    evt_irq_src_mux i_mux (
        .sel_i (cfg_q.sel),
        .evt_i (evt_i),
        .hit_o (sel_hit)
    );

    evt_irq_prescaler #(.CNT_W(CNT_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_we),
        .inc_i   (sel_hit || force_i),
        .prd_i   (cfg_q.prd),
        .cnt_o   (cnt_o),
        .match_o (match)
    );

    evt_irq_latch i_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .en_i    (cfg_q.en),
        .clr_i   (flag_clr_i),
        .flag_o  (flag_o),
        .irq_o   (irq_o)
    );

    // R7
    wr_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !flag_o) |=> !irq_o);
    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cfg_q.en);
endmodule

// File: tb/test_evt_irq_gen.sv
module test_evt_irq_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we, cfg_en, force_i, flag_clr_i;
    logic [2:0] cfg_sel;
    logic [1:0] cfg_prd;
    logic [5:0] evt_i;
    logic [1:0] cnt_o;
    logic       flag_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model state
    int   m_cnt = 0;
    int   m_prd = 0;
    logic m_en  = 0;
    logic m_flag = 0;
    logic [2:0] m_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_gen i_evt_irq_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
        .cfg_sel(cfg_sel), .cfg_prd(cfg_prd), .force_i(force_i),
        .flag_clr_i(flag_clr_i), .evt_i(evt_i), .cnt_o(cnt_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    // R2 bit index per source code, -1 for none
    function automatic int idx_of(input logic [2:0] s);
        case (s)
            3'b001: idx_of = 0;
            3'b010: idx_of = 1;
            3'b100: idx_of = 2;
            3'b101: idx_of = 3;
            3'b110: idx_of = 4;
            3'b111: idx_of = 5;
            default: idx_of = -1;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic en, input logic [2:0] sel,
                        input logic [1:0] prd, input logic [5:0] ev,
                        input logic frc, input logic clr, input string tag);
        int   ix;
        logic hit, f, match, e_irq;
        @(negedge clk);
        cfg_we = we; cfg_en = en; cfg_sel = sel; cfg_prd = prd;
        evt_i = ev; force_i = frc; flag_clr_i = clr;
        ix = idx_of(m_sel);
        hit = (ix >= 0) ? ev[ix] : 1'b0;
        f = m_flag && !clr;
        match = 1'b0;
        if (we) begin
            m_en = en; m_sel = sel; m_prd = int'(prd); m_cnt = 0;
        end else if (m_prd != 0 && (hit || frc)) begin
            if (m_cnt + 1 == m_prd) begin
                m_cnt = 0; match = 1'b1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        e_irq = match && m_en && !f;
        m_flag = f || e_irq;
        @(posedge clk);
        #1;
        check({tag, " cnt"}, int'(cnt_o), m_cnt);
        check({tag, " flag"}, int'(flag_o), int'(m_flag));
        check({tag, " irq"}, int'(irq_o), int'(e_irq));
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 6'b0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_en = 0; cfg_sel = 0; cfg_prd = 0;
        force_i = 0; flag_clr_i = 0; evt_i = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 flag", int'(flag_o), 0);
        check("R1 irq", int'(irq_o), 0);
        @(negedge clk); rst_n = 1;
        // R1 unconfigured: events and force ignored
        step(0, 0, 0, 0, 6'h3f, 1, 0, "R1 unconfigured");
        step(0, 0, 0, 0, 6'h3f, 0, 0, "R1 unconfigured");

        // R2 R3 R4 R8: sweep period x source code x event line
        for (int p = 1; p <= 3; p++) begin
            for (int s = 0; s < 8; s++) begin
                for (int b = 0; b < 6; b++) begin
                    step(1, 1, 3'(s), 2'(p), 6'b0, 0, 1, "R2 cfg");
                    for (int k = 0; k < 4; k++)
                        step(0, 0, 0, 0, 6'(1 << b), 0, 1, "R2 R3 R4 sweep");
                    // other lines alone must not count
                    step(0, 0, 0, 0, ~6'(1 << b), 0, 1, "R2 other lines");
                end
            end
        end

        // R5 period zero ignores events and force
        step(1, 1, 3'b001, 2'd0, 6'b0, 0, 1, "R5 cfg");
        for (int k = 0; k < 4; k++)
            step(0, 0, 0, 0, 6'h3f, 1, 0, "R5 disabled");

        // R6 force counts, force plus event counts once
        for (int p = 1; p <= 3; p++) begin
            step(1, 1, 3'b100, 2'(p), 6'b0, 0, 1, "R6 cfg");
            for (int k = 0; k < 4; k++)
                step(0, 0, 0, 0, 6'b0, 1, 1, "R6 force");
            for (int k = 0; k < 4; k++)
                step(0, 0, 0, 0, 6'b000100, 1, 1, "R6 force plus event");
        end

        // R7 write clears count, event in write cycle dropped
        step(1, 1, 3'b010, 2'd3, 6'b0, 0, 1, "R7 cfg");
        step(0, 0, 0, 0, 6'b000010, 0, 0, "R7 pre");
        step(0, 0, 0, 0, 6'b000010, 0, 0, "R7 pre");
        step(1, 1, 3'b010, 2'd3, 6'b000010, 1, 0, "R7 write with event");
        step(1, 1, 3'b010, 2'd1, 6'b000010, 1, 1, "R7 write period one");
        step(0, 0, 0, 0, 6'b000010, 0, 0, "R7 after");

        // R9 flag held, no pulses while set
        step(1, 1, 3'b001, 2'd1, 6'b0, 0, 1, "R9 cfg");
        for (int k = 0; k < 4; k++)
            step(0, 0, 0, 0, 6'b000001, 0, 0, "R9 held");
        idle("R9 idle");
        step(0, 0, 0, 0, 6'b0, 0, 1, "R9 clear");
        step(0, 0, 0, 0, 6'b000001, 0, 0, "R9 rearmed");

        // R10 clear and match in one cycle
        for (int k = 0; k < 3; k++)
            step(0, 0, 0, 0, 6'b000001, 0, 1, "R10 clear with match");
        step(1, 1, 3'b001, 2'd2, 6'b0, 0, 0, "R10 cfg");
        step(0, 0, 0, 0, 6'b000001, 0, 0, "R10 count");
        step(0, 0, 0, 0, 6'b000001, 0, 1, "R10 clear with match");

        // R11 enable off: counter wraps, flag untouched
        step(1, 0, 3'b111, 2'd2, 6'b0, 0, 1, "R11 cfg");
        for (int k = 0; k < 5; k++)
            step(0, 0, 0, 0, 6'b100000, 0, 0, "R11 disabled irq");
        idle("R11 idle");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule